// File: doc/BRIEF.md
# Dual-Channel Current-Mode PWM Gate Logic

This block is the digital core of a two-channel, fixed-frequency, current-mode PWM controller. Channel 0 (auxiliary) drives one gate. Channel 1 (main) drives a complementary pair: a primary gate and a rectifier gate. Analog comparators outside the block deliver already-digitized, clock-synchronous trip flags. Each channel receives its own one-cycle clock pulse strobe, which opens a conduction pulse. The trip flags then end that pulse early.

Each channel holds a reset-dominant pulse latch. The latch is cleared by any of the following:
- the ramp-over-feedback trip;
- the first current-limit trip;
- a low run enable;
- an active hiccup skip;
- a maximum on-time limit.

A second, higher current-limit trip turns the gate off and blocks the next two clock pulses. On the main channel, the primary and the rectifier gate are never high together. Each gate turns on only after a programmable dead time, counted in system clocks, following the other gate's turn-off.

Top module: `pwm_gate_top`

## Requirements
- R1: A clock pulse strobe sampled high at a rising edge, with no reset condition present, sets the channel latch. The auxiliary gate is high right after that edge.
- R2: The ramp trip sampled high clears the latch at that edge. When the ramp trip and a clock pulse arrive in the same cycle, the latch ends low (reset dominates).
- R3: The first current-limit trip ends only the current pulse. The next clock pulse sets the latch normally.
- R4: The second current-limit trip clears the latch and loads a skip count of two. While the count is nonzero, clock pulses do not set the latch, and each pulse lowers the count by one. A new second-limit trip during a skip reloads the count to two.
- R5: A gate that no reset condition ends stays high for exactly MAX_ON system cycles and then falls.
- R6: On the main channel, whenever the primary gate falls while run is high, the rectifier gate follows high after the dead time. After run rises, the rectifier gate comes up first, once the counter loaded during run-low has expired.
- R7: For a switching transition in either direction, the primary and rectifier gates are both low for exactly `deadCycles`+1 sampled cycles. They are never high in the same cycle.
- R8: Run sampled low forces the channel's gate outputs (including the rectifier gate) low after that edge, regardless of pulses. It also clears any pending skip count.
- R9: While reset is asserted, and after its release with idle inputs, all gate outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| auxPulse | input | 1 | Auxiliary channel clock pulse strobe |
| auxRampTrip | input | 1 | Auxiliary ramp exceeds feedback |
| auxLim1 | input | 1 | Auxiliary first current-limit trip |
| auxLim2 | input | 1 | Auxiliary second current-limit trip |
| auxRun | input | 1 | Auxiliary channel run enable |
| mainPulse | input | 1 | Main channel clock pulse strobe |
| mainRampTrip | input | 1 | Main ramp exceeds feedback |
| mainLim1 | input | 1 | Main first current-limit trip |
| mainLim2 | input | 1 | Main second current-limit trip |
| mainRun | input | 1 | Main channel run enable |
| deadCycles | input | DEAD_W | Non-overlap count in system cycles |
| auxGate | output | 1 | Auxiliary gate drive |
| mainGate | output | 1 | Main primary gate drive |
| mainGateComp | output | 1 | Main rectifier (complementary) gate drive |

## Verification
The auxiliary channel is driven through a cycle-by-cycle table. The table covers isolated pulses, a ramp trip alone and together with a pulse, a first-limit trip followed by a normal pulse, and a second-limit trip followed by back-to-back pulses. These cases separate reset-dominant set logic from set-dominant logic, and a one-pulse skip from a two-pulse skip. A reloaded skip and a run-low that clears a pending skip show whether the count restarts and whether run clears it. An unterminated pulse measures the on-time cap. On the main channel, turn-on and turn-off gaps are counted at two dead-time settings, so the gap is shown to follow the register with its fixed one-cycle offset. A monitor records any cycle where both outputs are high.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
  localparam int NCH         = 2;
  localparam int CH_AUX      = 0;
  localparam int CH_MAIN     = 1;
  localparam int SKIP_PULSES = 2;
  localparam int SKIP_W      = $clog2(SKIP_PULSES + 1);

  // Control-to-datapath strobes for one channel
  typedef struct packed {
    logic drive;   // latch wants the primary conducting
    logic run;     // channel enabled
  } gateStrobe_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_gate_pkg::*;
#(
  parameter int MAX_ON = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pulse,
  input  logic        rampTrip,
  input  logic        lim1,
  input  logic        lim2,
  input  logic        run,
  output gateStrobe_t strobe
);
  localparam int ON_W = (MAX_ON > 2) ? $clog2(MAX_ON) : 1;
  localparam logic [ON_W-1:0] ON_LAST = ON_W'(MAX_ON - 1);

  logic              latchQ;
  logic [SKIP_W-1:0] skipCnt;
  logic [ON_W-1:0]   onCnt;
  logic              skipActive;
  logic              maxHit;
  logic              resetReq;
  logic              setNow;

  assign skipActive = (skipCnt != '0);
  assign maxHit     = latchQ && (onCnt == ON_LAST);
  // reset-dominant: any reset source overrides the clock set
  assign resetReq   = rampTrip | lim1 | lim2 | ~run | skipActive | maxHit;
  assign setNow     = pulse & ~resetReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ <= 1'b0;
    end else if (resetReq) begin
      latchQ <= 1'b0;
    end else if (pulse) begin
      latchQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      onCnt <= '0;
    end else if (setNow) begin
      onCnt <= '0;
    end else if (latchQ) begin
      onCnt <= onCnt + 1'b1;
    end
  end

  // hiccup skip: counts clock pulses, reloaded by every second-limit trip
  always_ff @(posedge clk) begin
    if (!rstN) begin
      skipCnt <= '0;
    end else if (!run) begin
      skipCnt <= '0;
    end else if (lim2) begin
      skipCnt <= SKIP_W'(SKIP_PULSES);
    end else if (pulse && skipActive) begin
      skipCnt <= skipCnt - 1'b1;
    end
  end

  assign strobe.drive = latchQ;
  assign strobe.run   = run;

  p_reset_dominant_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pulse && rampTrip) |=> !strobe.drive)
    else $error("R2: pulse won over ramp trip");

  p_lim2_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    lim2 |=> !latchQ)
    else $error("R4: gate on after second limit");

  p_skip_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (skipActive && pulse) |=> !latchQ)
    else $error("R4: pulse accepted during skip");

  p_run_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (!latchQ && !skipActive))
    else $error("R8: state kept with run low");

  always_comb begin
    if (rstN && latchQ) begin
      p_on_bound_r5: assert (onCnt <= ON_LAST)
        else $error("R5: on-time beyond limit");
    end
  end
endmodule

// File: rtl/pwm_gate_path.sv
module pwm_gate_path
  import pwm_gate_pkg::*;
#(
  parameter int DEAD_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strobe,
  input  logic [DEAD_W-1:0] deadCycles,
  output logic              priGate,
  output logic              compGate
);
  logic [DEAD_W-1:0] deadCnt;
  logic              deadDone;

  assign deadDone = (deadCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priGate  <= 1'b0;
      compGate <= 1'b0;
      deadCnt  <= '0;
    end else if (!strobe.run) begin
      priGate  <= 1'b0;
      compGate <= 1'b0;
      deadCnt  <= deadCycles;
    end else if (strobe.drive) begin
      if (compGate) begin
        compGate <= 1'b0;
        deadCnt  <= deadCycles;
      end else if (!priGate) begin
        if (deadDone) priGate <= 1'b1;
        else          deadCnt <= deadCnt - 1'b1;
      end
    end else begin
      if (priGate) begin
        priGate <= 1'b0;
        deadCnt <= deadCycles;
      end else if (!compGate) begin
        if (deadDone) compGate <= 1'b1;
        else          deadCnt  <= deadCnt - 1'b1;
      end
    end
  end

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(priGate && compGate))
    else $error("R7: both gates high");

  p_run_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |=> (!priGate && !compGate))
    else $error("R8: gate high with run low");

  p_pri_needs_drive_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(priGate) |-> $past(strobe.drive))
    else $error("R6: primary rose without drive");

  p_comp_waits_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(priGate) |-> !compGate)
    else $error("R7: rectifier rose with primary falling");
endmodule

// File: rtl/pwm_gate_top.sv
module pwm_gate_top
  import pwm_gate_pkg::*;
#(
  parameter int MAX_ON = 12,
  parameter int DEAD_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              auxPulse,
  input  logic              auxRampTrip,
  input  logic              auxLim1,
  input  logic              auxLim2,
  input  logic              auxRun,
  input  logic              mainPulse,
  input  logic              mainRampTrip,
  input  logic              mainLim1,
  input  logic              mainLim2,
  input  logic              mainRun,
  input  logic [DEAD_W-1:0] deadCycles,
  output logic              auxGate,
  output logic              mainGate,
  output logic              mainGateComp
);
  logic [NCH-1:0] pulseV, rampV, lim1V, lim2V, runV;
  gateStrobe_t    strobes [NCH];

  assign pulseV = {mainPulse,    auxPulse};
  assign rampV  = {mainRampTrip, auxRampTrip};
  assign lim1V  = {mainLim1,     auxLim1};
  assign lim2V  = {mainLim2,     auxLim2};
  assign runV   = {mainRun,      auxRun};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pwm_ctrl #(.MAX_ON(MAX_ON)) u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .pulse    (pulseV[ch]),
      .rampTrip (rampV[ch]),
      .lim1     (lim1V[ch]),
      .lim2     (lim2V[ch]),
      .run      (runV[ch]),
      .strobe   (strobes[ch])
    );
  end

  assign auxGate = strobes[CH_AUX].drive & strobes[CH_AUX].run;

  pwm_gate_path #(.DEAD_W(DEAD_W)) u_main_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobes[CH_MAIN]),
    .deadCycles (deadCycles),
    .priGate    (mainGate),
    .compGate   (mainGateComp)
  );
endmodule

// File: tb/pwm_gate_top_tb.sv
module pwm_gate_top_tb;
  localparam int MAX_ON = 12;
  localparam int DEAD_W = 6;
  localparam int NVEC   = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic auxPulse = 0, auxRampTrip = 0, auxLim1 = 0, auxLim2 = 0, auxRun = 0;
  logic mainPulse = 0, mainRampTrip = 0, mainLim1 = 0, mainLim2 = 0, mainRun = 0;
  logic [DEAD_W-1:0] deadCycles = '0;
  logic auxGate, mainGate, mainGateComp;

  int checks = 0;
  int errors = 0;
  int overlapSeen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_gate_top #(.MAX_ON(MAX_ON), .DEAD_W(DEAD_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .auxPulse(auxPulse), .auxRampTrip(auxRampTrip), .auxLim1(auxLim1),
    .auxLim2(auxLim2), .auxRun(auxRun),
    .mainPulse(mainPulse), .mainRampTrip(mainRampTrip), .mainLim1(mainLim1),
    .mainLim2(mainLim2), .mainRun(mainRun),
    .deadCycles(deadCycles),
    .auxGate(auxGate), .mainGate(mainGate), .mainGateComp(mainGateComp)
  );

  // row bits: {pulse, ramp, lim1, lim2, run, expected gate after the edge}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b000010, 6'b100011, 6'b000011, 6'b010010,
    6'b110010, 6'b100011, 6'b001010, 6'b100011,
    6'b000110, 6'b100010, 6'b000010, 6'b100010,
    6'b100011, 6'b000110, 6'b100010, 6'b000110,
    6'b100010, 6'b100010, 6'b100011, 6'b100000,
    6'b100011, 6'b000110, 6'b000000, 6'b100011
  };
  localparam int TAG [NVEC] = '{
    1, 1, 1, 2, 2, 1, 3, 3, 4, 4, 4, 4,
    4, 4, 4, 4, 4, 4, 4, 8, 1, 8, 8, 8
  };

  function automatic string tagName(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN && mainGate && mainGateComp) overlapSeen++;

  // counts samples with both main gates low until the target gate is high
  task automatic measureGap(input bit waitPri, output int gap, output bit seen);
    gap = 0;
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (waitPri ? mainGate : mainGateComp) begin
        seen = 1;
        break;
      end
      if (!mainGate && !mainGateComp) gap++;
    end
  endtask

  task automatic mainDeadTest(input int d, input bit useLim1);
    int gap;
    bit seen;
    deadCycles = DEAD_W'(d);
    mainRun = 0;
    repeat (2) @(negedge clk);
    mainRun = 1;
    measureGap(1'b0, gap, seen);
    chk("R6 startup rectifier on", int'(seen), 1);
    chk("R6 startup wait", gap, d);
    repeat (2) @(negedge clk);
    mainPulse = 1;
    @(negedge clk);
    mainPulse = 0;
    measureGap(1'b1, gap, seen);
    chk("R7 turn-on gap", gap, d + 1);
    repeat (2) @(negedge clk);
    if (useLim1) mainLim1 = 1; else mainRampTrip = 1;
    @(negedge clk);
    mainLim1 = 0;
    mainRampTrip = 0;
    measureGap(1'b0, gap, seen);
    chk("R6 rectifier follows primary", int'(seen), 1);
    chk("R7 turn-off gap", gap, d + 1);
  endtask

  initial begin
    int hiCount;
    // R9: outputs during reset
    repeat (3) @(negedge clk);
    chk("R9 reset aux", int'(auxGate), 0);
    chk("R9 reset main", int'(mainGate | mainGateComp), 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk("R9 idle after reset", int'(auxGate | mainGate | mainGateComp), 0);

    // table walk on the auxiliary channel
    for (int i = 0; i < NVEC; i++) begin
      {auxPulse, auxRampTrip, auxLim1, auxLim2, auxRun} = VEC[i][5:1];
      @(negedge clk);
      chk($sformatf("%s row %0d", tagName(TAG[i]), i), int'(auxGate), int'(VEC[i][0]));
    end
    {auxPulse, auxRampTrip, auxLim1, auxLim2} = '0;
    auxRun = 1;

    // R5: unterminated pulse length (clear the one open from the last row)
    auxRampTrip = 1;
    @(negedge clk);
    auxRampTrip = 0;
    auxPulse = 1;
    @(negedge clk);
    auxPulse = 0;
    hiCount = int'(auxGate);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      hiCount += int'(auxGate);
    end
    chk("R5 max on-time", hiCount, MAX_ON);

    // R6/R7: complementary pair at two dead settings
    mainDeadTest(3, 1'b0);
    mainDeadTest(0, 1'b1);

    // R8: run low while primary conducts
    deadCycles = DEAD_W'(1);
    mainPulse = 1;
    @(negedge clk);
    mainPulse = 0;
    repeat (4) @(negedge clk);
    chk("R8 primary on before run drop", int'(mainGate), 1);
    mainRun = 0;
    @(negedge clk);
    chk("R8 main pair low", int'(mainGate | mainGateComp), 0);
    repeat (3) @(negedge clk);
    chk("R8 rectifier held low", int'(mainGateComp), 0);

    chk("R7 no overlap seen", overlapSeen, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule